// File: doc/BRIEF.md
# Energy Efficient Ethernet Low Power Idle Controller

This block decides when the transmit side of an Ethernet MAC may put the line into Low Power Idle (LPI) and when it must come back out. Software drives a link-good bit, two enable bits, an optional clock-gating bit and one packed timer word. The block counts millisecond ticks to prove the link has been good long enough. When the transmit path is idle and that time has elapsed, it raises an LPI request toward the PHY interface.

A transmit request, a lost link or a dropped enable ends LPI. The block then holds the transmit path off until a programmed number of microsecond ticks has passed. A transmit-ready output tells the upstream MAC logic when frames may flow again. Two sticky flags record entry and exit events, and a read strobe clears them.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `lpi_state` is 0 (idle), `lpi_req` and `tx_clk_gate_en` are 0, `tx_ready` is 1, and both sticky flags are 0.
- R2: `cfg_timer` bits 15:0 hold the wake time, counted in `us_tick` pulses. Bits 25:16 hold the link-good time, counted in `ms_tick` pulses.
- R3: LPI is entered, and `lpi_req` rises, only when all four of these hold:
  - `cfg_lpi_en`, `cfg_auto_en` and `cfg_link_ok` are all 1.
  - The block has waited in state 1.
  - At least the link-good time's worth of `ms_tick` pulses has been counted since `cfg_link_ok` last became 1.
  - `tx_req` is 0.
- R4: While in LPI, `tx_req` at 1 moves the block to the wake state (`lpi_state` 3) on the next clock edge, and `lpi_req` falls.
- R5: While in LPI, clearing `cfg_link_ok`, `cfg_lpi_en` or `cfg_auto_en` also moves the block to the wake state.
- R6: The block leaves the wake state for idle (`lpi_state` 0) on the first clock edge at which the wake counter is at least the wake time. The wake counter starts at 0 on entry and counts `us_tick` pulses while in the wake state.
- R7: `tx_ready` is 0 in LPI (`lpi_state` 2) and in wake (3), and 1 in idle (0) and link-wait (1).
- R8: `tx_clk_gate_en` is 1 exactly when `lpi_req` is 1 and `cfg_gate_en` is 1.
- R9: Each entry into LPI sets `stat_entered`, and each move from LPI to wake sets `stat_exited`. `stat_rd` clears both flags on the next edge, but an event in the same cycle keeps its flag set.
- R10: Clearing `cfg_link_ok` resets the link-good count to 0, so a later entry needs the full link-good time again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cfg_lpi_en | input | 1 | LPI enable |
| cfg_auto_en | input | 1 | Automatic entry enable |
| cfg_link_ok | input | 1 | Software-written PHY link-good bit |
| cfg_gate_en | input | 1 | Allow transmit clock gating in LPI |
| cfg_timer | input | 26 | Packed link-good time (25:16) and wake time (15:0) |
| tx_req | input | 1 | Transmit path has data to send |
| stat_rd | input | 1 | Read strobe that clears the sticky flags |
| lpi_req | output | 1 | LPI request toward the PHY interface |
| tx_clk_gate_en | output | 1 | Transmit clock gate enable |
| tx_ready | output | 1 | Transmission may proceed |
| lpi_state | output | 2 | 0 idle, 1 link-wait, 2 LPI, 3 wake |
| stat_entered | output | 1 | Sticky LPI-entry flag |
| stat_exited | output | 1 | Sticky LPI-exit flag |

## Verification
The bench targets the tick on which the link-good count first reaches its limit. A design that compares off by one enters LPI one millisecond early or late. It also holds `tx_req` high after the link time has expired, where a design that ignores activity would enter LPI with data pending. Dropping and restoring the link shows whether the count really restarts; a stale count would re-enter at once. Zero timer values, and a read strobe landing in the same cycle as an entry event, catch a wake state that lingers and a clear that erases a fresh event.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  localparam int WAKE_W   = 16;
  localparam int LINK_W   = 10;
  localparam int WAKE_LSB = 0;
  localparam int LINK_LSB = WAKE_LSB + WAKE_W;
  localparam int CFG_W    = LINK_LSB + LINK_W;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LINK = 2'd1,
    ST_LPI       = 2'd2,
    ST_WAKE      = 2'd3
  } lpi_state_e;

  function automatic logic [WAKE_W-1:0] f_wake_time(input logic [CFG_W-1:0] cfg);
    return cfg[WAKE_LSB +: WAKE_W];
  endfunction

  function automatic logic [LINK_W-1:0] f_link_time(input logic [CFG_W-1:0] cfg);
    return cfg[LINK_LSB +: LINK_W];
  endfunction

  function automatic logic f_tx_blocked(input lpi_state_e st);
    return (st == ST_LPI) || (st == ST_WAKE);
  endfunction

endpackage

// File: rtl/eee_tick_timer.sv
module eee_tick_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= f_sat_inc(cnt_q);
  end

  assign done = (cnt_q >= limit);

  p_cnt_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       allow,
  input  logic       link_done,
  input  logic       wake_done,
  input  logic       tx_req,
  output lpi_state_e state_q,
  output logic       enter_ev,
  output logic       exit_ev
);

  lpi_state_e state_d;

  always_comb begin
    state_d  = state_q;
    enter_ev = 1'b0;
    exit_ev  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (allow) state_d = ST_WAIT_LINK;
      end
      ST_WAIT_LINK: begin
        if (!allow) begin
          state_d = ST_IDLE;
        end else if (link_done && !tx_req) begin
          state_d  = ST_LPI;
          enter_ev = 1'b1;
        end
      end
      ST_LPI: begin
        if (!allow || tx_req) begin
          state_d = ST_WAKE;
          exit_ev = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wake_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  p_entry_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LPI && $past(state_q) != ST_LPI)
      |-> $past(allow && link_done && !tx_req && state_q == ST_WAIT_LINK));

  p_exit_on_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LPI && tx_req) |=> (state_q == ST_WAKE));

  p_exit_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LPI && !allow) |=> (state_q == ST_WAKE));

  p_wake_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && !wake_done) |=> (state_q == ST_WAKE));

endmodule

// File: rtl/eee_lpi_sticky.sv
module eee_lpi_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_ev,
  input  logic exit_ev,
  input  logic rd_clr,
  output logic entered_q,
  output logic exited_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entered_q <= 1'b0;
      exited_q  <= 1'b0;
    end else begin
      entered_q <= enter_ev | (entered_q & ~rd_clr);
      exited_q  <= exit_ev  | (exited_q  & ~rd_clr);
    end
  end

  p_entry_recorded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> entered_q);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !exit_ev) |=> !exited_q);

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             us_tick,
  input  logic             cfg_lpi_en,
  input  logic             cfg_auto_en,
  input  logic             cfg_link_ok,
  input  logic             cfg_gate_en,
  input  logic [CFG_W-1:0] cfg_timer,
  input  logic             tx_req,
  input  logic             stat_rd,
  output logic             lpi_req,
  output logic             tx_clk_gate_en,
  output logic             tx_ready,
  output logic [1:0]       lpi_state,
  output logic             stat_entered,
  output logic             stat_exited
);

  lpi_state_e        state_q;
  logic              allow;
  logic              link_done;
  logic              wake_done;
  logic              enter_ev;
  logic              exit_ev;
  logic              wake_clr;
  logic [LINK_W-1:0] link_cnt;
  logic [WAKE_W-1:0] wake_cnt;

  assign allow    = cfg_lpi_en & cfg_auto_en & cfg_link_ok;
  assign wake_clr = (state_q != ST_WAKE);

  eee_tick_timer #(.CNT_W(LINK_W)) u_link_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~cfg_link_ok),
    .tick  (ms_tick),
    .limit (f_link_time(cfg_timer)),
    .cnt_q (link_cnt),
    .done  (link_done)
  );

  eee_tick_timer #(.CNT_W(WAKE_W)) u_wake_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wake_clr),
    .tick  (us_tick),
    .limit (f_wake_time(cfg_timer)),
    .cnt_q (wake_cnt),
    .done  (wake_done)
  );

  eee_lpi_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .allow     (allow),
    .link_done (link_done),
    .wake_done (wake_done),
    .tx_req    (tx_req),
    .state_q   (state_q),
    .enter_ev  (enter_ev),
    .exit_ev   (exit_ev)
  );

  eee_lpi_sticky u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_ev  (enter_ev),
    .exit_ev   (exit_ev),
    .rd_clr    (stat_rd),
    .entered_q (stat_entered),
    .exited_q  (stat_exited)
  );

  assign lpi_req        = (state_q == ST_LPI);
  assign tx_clk_gate_en = lpi_req & cfg_gate_en;
  assign tx_ready       = ~f_tx_blocked(state_q);
  assign lpi_state      = state_q;

  p_link_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_link_ok |=> (link_cnt == '0));

  p_wake_starts_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ev |=> (wake_cnt == '0));

  p_ready_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ev |=> !tx_ready);

endmodule

// File: tb/eee_lpi_ctrl_tb_top.sv
module eee_lpi_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0, us_tick = 1'b0;
  logic        cfg_lpi_en = 1'b0, cfg_auto_en = 1'b0, cfg_link_ok = 1'b0, cfg_gate_en = 1'b0;
  logic [25:0] cfg_timer = '0;
  logic        tx_req = 1'b0, stat_rd = 1'b0;
  logic        lpi_req, tx_clk_gate_en, tx_ready, stat_entered, stat_exited;
  logic [1:0]  lpi_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eee_lpi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .us_tick(us_tick),
    .cfg_lpi_en(cfg_lpi_en), .cfg_auto_en(cfg_auto_en), .cfg_link_ok(cfg_link_ok),
    .cfg_gate_en(cfg_gate_en), .cfg_timer(cfg_timer), .tx_req(tx_req), .stat_rd(stat_rd),
    .lpi_req(lpi_req), .tx_clk_gate_en(tx_clk_gate_en), .tx_ready(tx_ready),
    .lpi_state(lpi_state), .stat_entered(stat_entered), .stat_exited(stat_exited)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_st = 0, m_link = 0, m_wake = 0;
  bit m_ent = 0, m_ext = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_link = 0; m_wake = 0; m_ent = 0; m_ext = 0;
    end else begin
      bit en, ldone, wdone, ev_in, ev_out;
      int nxt;
      en = cfg_lpi_en && cfg_auto_en && cfg_link_ok;
      ldone = m_link >= int'(cfg_timer[25:16]);
      wdone = m_wake >= int'(cfg_timer[15:0]);
      ev_in = 0; ev_out = 0; nxt = m_st;
      if (m_st == 0 && en) nxt = 1;
      else if (m_st == 1) begin
        if (!en) nxt = 0;
        else if (ldone && !tx_req) begin nxt = 2; ev_in = 1; end
      end else if (m_st == 2 && (!en || tx_req)) begin nxt = 3; ev_out = 1; end
      else if (m_st == 3 && wdone) nxt = 0;
      if (!cfg_link_ok) m_link = 0;
      else if (ms_tick && m_link < 1023) m_link++;
      if (m_st != 3) m_wake = 0;
      else if (us_tick && m_wake < 65535) m_wake++;
      m_ent = ev_in  ? 1'b1 : (stat_rd ? 1'b0 : m_ent);
      m_ext = ev_out ? 1'b1 : (stat_rd ? 1'b0 : m_ext);
      m_st = nxt;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(lpi_req == (m_st == 2), "R3 model lpi_req", int'(lpi_req), int'(m_st == 2));
      chk(int'(lpi_state) == m_st, "R6 model lpi_state", int'(lpi_state), m_st);
      chk(tx_ready == !(m_st >= 2), "R7 model tx_ready", int'(tx_ready), int'(!(m_st >= 2)));
      chk(tx_clk_gate_en == ((m_st == 2) && cfg_gate_en), "R8 model gate",
          int'(tx_clk_gate_en), int'((m_st == 2) && cfg_gate_en));
      chk(stat_entered == m_ent, "R9 model entered", int'(stat_entered), int'(m_ent));
      chk(stat_exited == m_ext, "R9 model exited", int'(stat_exited), int'(m_ext));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ms_pulse();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    #1;
  endtask

  task automatic us_pulse();
    @(negedge clk); us_tick = 1'b1;
    @(negedge clk); us_tick = 1'b0;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(lpi_state == 2'd0, "R1 reset state", int'(lpi_state), 0);
    chk(tx_ready && !lpi_req && !tx_clk_gate_en, "R1 reset outputs",
        int'({tx_ready, lpi_req, tx_clk_gate_en}), 4);
    chk(!stat_entered && !stat_exited, "R1 reset flags", int'({stat_entered, stat_exited}), 0);

    // R2: link time 3 ms, wake time 2 us
    @(negedge clk);
    cfg_timer = {10'd3, 16'd2};
    cfg_lpi_en = 1'b1; cfg_auto_en = 1'b1; cfg_link_ok = 1'b1;
    cyc(2);
    chk(lpi_state == 2'd1, "R3 waiting for link time", int'(lpi_state), 1);
    ms_pulse(); ms_pulse(); cyc(2);
    chk(!lpi_req, "R2 no entry before 3 ms", int'(lpi_req), 0);
    ms_pulse(); cyc(1);
    chk(lpi_req && lpi_state == 2'd2, "R2 entry after 3 ms", int'(lpi_state), 2);
    chk(stat_entered, "R9 entry flag", int'(stat_entered), 1);

    @(negedge clk); cfg_gate_en = 1'b1; #1;
    chk(tx_clk_gate_en, "R8 gate on in LPI", int'(tx_clk_gate_en), 1);
    @(negedge clk); cfg_gate_en = 1'b0; #1;
    chk(!tx_clk_gate_en, "R8 gate off when disabled", int'(tx_clk_gate_en), 0);

    // R4: transmit request wakes
    @(negedge clk); tx_req = 1'b1;
    cyc(1);
    chk(lpi_state == 2'd3 && !lpi_req, "R4 wake on tx_req", int'(lpi_state), 3);
    chk(!tx_ready, "R7 not ready in wake", int'(tx_ready), 0);
    chk(stat_exited, "R9 exit flag", int'(stat_exited), 1);
    us_pulse();
    chk(!tx_ready, "R6 still waking after 1 us", int'(tx_ready), 0);
    us_pulse();
    chk(!tx_ready, "R6 still waking at count edge", int'(tx_ready), 0);
    cyc(1);
    chk(tx_ready, "R6 ready after wake time", int'(tx_ready), 1);
    cyc(4);
    chk(lpi_state == 2'd1, "R3 tx activity blocks entry", int'(lpi_state), 1);
    @(negedge clk); tx_req = 1'b0;
    cyc(1);
    chk(lpi_state == 2'd2, "R3 entry once tx idle", int'(lpi_state), 2);

    // R9 read clears
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; #1;
    chk(!stat_entered && !stat_exited, "R9 read clears", int'({stat_entered, stat_exited}), 0);

    // R5 / R10 link lost
    @(negedge clk); cfg_link_ok = 1'b0;
    cyc(1);
    chk(lpi_state == 2'd3, "R5 link loss exits", int'(lpi_state), 3);
    us_pulse(); us_pulse(); cyc(2);
    @(negedge clk); cfg_link_ok = 1'b1;
    cyc(2);
    ms_pulse(); ms_pulse(); cyc(3);
    chk(lpi_state == 2'd1, "R10 link count restarted", int'(lpi_state), 1);
    ms_pulse(); cyc(1);
    chk(lpi_state == 2'd2, "R10 entry after full time", int'(lpi_state), 2);

    // R5 auto off
    @(negedge clk); cfg_auto_en = 1'b0;
    cyc(1);
    chk(lpi_state == 2'd3, "R5 auto clear exits", int'(lpi_state), 3);
    us_pulse(); us_pulse(); cyc(6);
    chk(lpi_state == 2'd0 && !lpi_req, "R3 no entry without auto", int'(lpi_state), 0);

    // zero timers, read in same cycle as entry
    @(negedge clk); cfg_timer = '0; stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; cfg_auto_en = 1'b1;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; #1;
    chk(stat_entered && lpi_state == 2'd2, "R9 event beats read", int'(stat_entered), 1);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; #1;
    chk(lpi_state == 2'd3, "R6 zero wake time one cycle", int'(lpi_state), 3);
    cyc(1);
    chk(lpi_state == 2'd0, "R6 zero wake back to idle", int'(lpi_state), 0);
    cyc(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule